// File: doc/BRIEF.md
# Expanding Opcode Instruction Decoder

This block decodes 16-bit instruction words in which the operation code grows longer as the number of operand fields shrinks. The word is read as four 4-bit slots. A leading slot other than all-ones names a three-address operation. An all-ones leading slot is an escape to the two-address class, where the second slot carries the operation. Two all-ones slots escape to the one-address class, and three escape to the zero-address class. The decoder counts the leading all-ones slots. From that count it takes the class, the slot holding the operation and the slots holding operands.

Each decoded result carries a class code and a single operation index that is unique across all classes. It also carries up to three 4-bit operand fields and an illegal flag. When a mode input is set, a three-address word instead gives one 12-bit operand. Results are captured in a register on the clock edge that samples a valid input. They stay unchanged until the next valid input arrives.

Top module: `expanding_opcode_decoder`

## Requirements
- R1: After a synchronous reset, every output is zero: valid_out, cls_out, op_idx, all fields, addr_wide, wide_out and illegal_out.
- R2: If instr[15:12] is in the range 0 to 14 and wide_mode is 0, the decoder gives cls_out=2'b11, op_idx=instr[15:12], field_a=instr[11:8], field_b=instr[7:4] and field_c=instr[3:0], with wide_out=0 and addr_wide=0.
- R3: If instr[15:12] is in the range 0 to 14 and wide_mode is 1, the decoder gives cls_out=2'b11, op_idx=instr[15:12], addr_wide=instr[11:0] and wide_out=1, with all three 4-bit fields zero.
- R4: If instr[15:12]=4'hF and instr[11:8]!=4'hF, the decoder gives cls_out=2'b10, op_idx=16+instr[11:8], field_a=instr[7:4], field_b=instr[3:0] and field_c=0.
- R5: If instr[15:8]=8'hFF and instr[7:4]!=4'hF, the decoder gives cls_out=2'b01, op_idx=32+instr[7:4], field_a=instr[3:0] and field_b=field_c=0.
- R6: If instr[15:4]=12'hFFF and instr[3:0]!=4'hF, the decoder gives cls_out=2'b00, op_idx=48+instr[3:0] and all fields zero.
- R7: The word 16'hFFFF sets illegal_out=1 with cls_out=2'b00, op_idx=63 and all fields zero. Every other word leaves illegal_out at 0.
- R8: wide_mode has no effect on words outside the three-address class: wide_out and addr_wide stay 0 for them.
- R9: The outputs take the decode of the word presented with valid_in high on the rising edge that samples it. valid_out is high for exactly the cycle after each cycle in which valid_in is high.
- R10: While valid_in is low, every decoded output keeps its last value, whatever instr and wide_mode do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Qualifies instr and wide_mode this cycle |
| wide_mode | input | 1 | Read three-address operands as one 12-bit value |
| instr | input | 16 | Instruction word |
| valid_out | output | 1 | Decoded result was captured on the last edge |
| cls_out | output | 2 | Class: 11 three-, 10 two-, 01 one-, 00 zero-address |
| op_idx | output | 6 | Operation index unique across classes |
| field_a | output | 4 | First operand field |
| field_b | output | 4 | Second operand field |
| field_c | output | 4 | Third operand field |
| addr_wide | output | 12 | Single 12-bit operand in wide mode |
| wide_out | output | 1 | addr_wide holds the operand |
| illegal_out | output | 1 | Word is the reserved all-ones code |

## Verification
The assertions assume that valid_in, wide_mode and instr are stable and known at each rising edge while reset is low. They also assume that reset is held for at least one edge before decoding starts. The bench changes every input only on falling edges and holds reset for several cycles at the start. It samples the outputs on the next falling edge, where each decoded word has had exactly one rising edge to register. The hold checks change instr and wide_mode while valid_in is low, so a decoder that ignored valid_in would show the change at its outputs.

// File: rtl/xdec_pkg.sv
package xdec_pkg;

    localparam int FW     = 4;
    localparam int NSLOT  = 4;
    localparam int WORD_W = FW * NSLOT;
    localparam int LVL_W  = $clog2(NSLOT);
    localparam int DEP_W  = $clog2(NSLOT + 1);
    localparam int IDX_W  = LVL_W + FW;
    localparam int NOPND  = NSLOT - 1;
    localparam int WIDE_W = WORD_W - FW;

    typedef enum logic [LVL_W-1:0] {
        CLS_ZERO  = 2'b00,
        CLS_ONE   = 2'b01,
        CLS_TWO   = 2'b10,
        CLS_THREE = 2'b11
    } cls_t;

    typedef struct packed {
        cls_t                      cls;
        logic [IDX_W-1:0]          idx;
        logic [NOPND-1:0][FW-1:0]  fld;
        logic [WIDE_W-1:0]         wide_addr;
        logic                      wide;
        logic                      illegal;
    } dec_t;

    // Slot 0 is the most significant nibble; out-of-range slots read as zero.
    function automatic logic [FW-1:0] slot_of(input logic [WORD_W-1:0] w, input int s);
        logic [FW-1:0] r;
        r = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (i == s) r = w[WORD_W-1-i*FW -: FW];
        end
        return r;
    endfunction

endpackage

// File: rtl/xdec_prefix.sv
module xdec_prefix
    import xdec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [DEP_W-1:0]  depth,
    output logic              reserved
);
    logic [NSLOT-1:0] ones;

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_slot
            assign ones[g] = &word[WORD_W-1-g*FW -: FW];
        end
    endgenerate

    // Count the run of all-ones slots from the top of the word.
    always_comb begin
        logic run;
        run   = 1'b1;
        depth = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (run && ones[i]) depth = DEP_W'(i + 1);
            else                run   = 1'b0;
        end
    end

    assign reserved = (depth == DEP_W'(NSLOT));

endmodule

// File: rtl/xdec_fields.sv
module xdec_fields
    import xdec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [DEP_W-1:0]  depth,
    input  logic              reserved,
    input  logic              wide_mode,
    output dec_t              dec
);
    logic [LVL_W-1:0] lvl;
    logic             top_class;

    assign lvl       = depth[LVL_W-1:0];
    assign top_class = (depth == '0);

    always_comb begin
        dec = '0;
        if (reserved) begin
            dec.illegal = 1'b1;
            dec.cls     = CLS_ZERO;
            dec.idx     = '1;
        end else begin
            dec.cls = cls_t'(LVL_W'(NSLOT - 1) - lvl);
            dec.idx = {lvl, slot_of(word, int'(depth))};
            if (top_class && wide_mode) begin
                dec.wide      = 1'b1;
                dec.wide_addr = word[WIDE_W-1:0];
            end else begin
                for (int k = 0; k < NOPND; k++) begin
                    dec.fld[k] = slot_of(word, int'(depth) + 1 + k);
                end
            end
        end
    end

endmodule

// File: rtl/expanding_opcode_decoder.sv
module expanding_opcode_decoder
    import xdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic              wide_mode,
    input  logic [15:0]       instr,
    output logic              valid_out,
    output logic [1:0]        cls_out,
    output logic [5:0]        op_idx,
    output logic [3:0]        field_a,
    output logic [3:0]        field_b,
    output logic [3:0]        field_c,
    output logic [11:0]       addr_wide,
    output logic              wide_out,
    output logic              illegal_out
);
    logic [DEP_W-1:0] depth;
    logic             reserved;
    dec_t             dec_nxt;
    dec_t             dec_q;
    logic             vld_q;

    xdec_prefix u_prefix (
        .word     (instr),
        .depth    (depth),
        .reserved (reserved)
    );

    xdec_fields u_fields (
        .word      (instr),
        .depth     (depth),
        .reserved  (reserved),
        .wide_mode (wide_mode),
        .dec       (dec_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= valid_in;
            if (valid_in) dec_q <= dec_nxt;
        end
    end

    assign valid_out   = vld_q;
    assign cls_out     = dec_q.cls;
    assign op_idx      = dec_q.idx;
    assign field_a     = dec_q.fld[0];
    assign field_b     = dec_q.fld[1];
    assign field_c     = dec_q.fld[2];
    assign addr_wide   = dec_q.wide_addr;
    assign wide_out    = dec_q.wide;
    assign illegal_out = dec_q.illegal;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(op_idx) && $stable(cls_out) && $stable(field_a)
                       && $stable(addr_wide) && $stable(illegal_out)));

    // R7
    reserved_word_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && instr == 16'hFFFF) |=> (illegal_out && cls_out == 2'b00));

    // R2
    three_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cls_out == 2'b11) |-> (op_idx < 6'd15));

    // R8
    wide_class_chk: assert property (@(posedge clk) disable iff (rst)
        wide_out |-> (cls_out == 2'b11));

endmodule

// File: tb/expanding_opcode_decoder_test.sv
module expanding_opcode_decoder_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_in;
    logic        wide_mode;
    logic [15:0] instr;
    logic        valid_out;
    logic [1:0]  cls_out;
    logic [5:0]  op_idx;
    logic [3:0]  field_a, field_b, field_c;
    logic [11:0] addr_wide;
    logic        wide_out;
    logic        illegal_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    expanding_opcode_decoder uut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .wide_mode(wide_mode),
        .instr(instr), .valid_out(valid_out), .cls_out(cls_out), .op_idx(op_idx),
        .field_a(field_a), .field_b(field_b), .field_c(field_c),
        .addr_wide(addr_wide), .wide_out(wide_out), .illegal_out(illegal_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int cls, input int idx, input int fa,
                           input int fb, input int fc, input int wa, input int w, input int il);
        chk(req, "cls_out",     int'(cls_out),     cls);
        chk(req, "op_idx",      int'(op_idx),      idx);
        chk(req, "field_a",     int'(field_a),     fa);
        chk(req, "field_b",     int'(field_b),     fb);
        chk(req, "field_c",     int'(field_c),     fc);
        chk(req, "addr_wide",   int'(addr_wide),   wa);
        chk(req, "wide_out",    int'(wide_out),    w);
        chk(req, "illegal_out", int'(illegal_out), il);
    endtask

    // Present one word for one cycle; leaves the bench on the falling edge after capture.
    task automatic issue(input logic [15:0] w, input logic wm);
        @(negedge clk);
        instr     = w;
        wide_mode = wm;
        valid_in  = 1'b1;
        @(negedge clk);
        valid_in  = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; valid_in = 1'b0; wide_mode = 1'b0; instr = 16'h0000;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1", "valid_out", int'(valid_out), 0);
        chk_all("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_three();
        issue(16'h3A5C, 1'b0);
        chk_all("R2", 3, 3, 'hA, 'h5, 'hC, 0, 0, 0);
        issue(16'hE123, 1'b0);
        chk_all("R2", 3, 14, 1, 2, 3, 0, 0, 0);
        issue(16'h0000, 1'b0);
        chk_all("R2", 3, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_wide();
        issue(16'h7ABC, 1'b1);
        chk_all("R3", 3, 7, 0, 0, 0, 'hABC, 1, 0);
        issue(16'hEFFF, 1'b1);
        chk_all("R3", 3, 14, 0, 0, 0, 'hFFF, 1, 0);
    endtask

    task automatic t_two();
        issue(16'hF4C1, 1'b0);
        chk_all("R4", 2, 20, 'hC, 1, 0, 0, 0, 0);
        issue(16'hFEFF, 1'b0);
        chk_all("R4", 2, 30, 'hF, 'hF, 0, 0, 0, 0);
    endtask

    task automatic t_one();
        issue(16'hFF39, 1'b0);
        chk_all("R5", 1, 35, 9, 0, 0, 0, 0, 0);
        issue(16'hFFEF, 1'b0);
        chk_all("R5", 1, 46, 'hF, 0, 0, 0, 0, 0);
    endtask

    task automatic t_zero();
        issue(16'hFFF5, 1'b0);
        chk_all("R6", 0, 53, 0, 0, 0, 0, 0, 0);
        issue(16'hFFFE, 1'b0);
        chk_all("R6", 0, 62, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_illegal();
        issue(16'hFFFF, 1'b0);
        chk_all("R7", 0, 63, 0, 0, 0, 0, 0, 1);
        issue(16'hFFFF, 1'b1);
        chk_all("R7", 0, 63, 0, 0, 0, 0, 0, 1);
        issue(16'hFFF0, 1'b0);
        chk("R7", "illegal_out near miss", int'(illegal_out), 0);
    endtask

    task automatic t_mode_ignored();
        issue(16'hF4C1, 1'b1);
        chk_all("R8", 2, 20, 'hC, 1, 0, 0, 0, 0);
        issue(16'hFF39, 1'b1);
        chk_all("R8", 1, 35, 9, 0, 0, 0, 0, 0);
        issue(16'hFFF5, 1'b1);
        chk_all("R8", 0, 53, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_timing();
        @(negedge clk);
        instr = 16'h9876; wide_mode = 1'b0; valid_in = 1'b1;
        chk("R9", "valid_out before edge", int'(valid_out), 0);
        @(negedge clk);
        chk("R9", "valid_out after edge", int'(valid_out), 1);
        chk("R9", "op_idx after edge", int'(op_idx), 9);
        instr = 16'h2468;
        @(negedge clk);
        chk("R9", "valid_out back-to-back", int'(valid_out), 1);
        chk("R9", "op_idx back-to-back", int'(op_idx), 2);
        valid_in = 1'b0;
        @(negedge clk);
        chk("R9", "valid_out drop", int'(valid_out), 0);
    endtask

    task automatic t_hold();
        issue(16'h5123, 1'b0);
        instr = 16'hFFFF; wide_mode = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "valid_out idle", int'(valid_out), 0);
        chk_all("R10", 3, 5, 1, 2, 3, 0, 0, 0);
        instr = 16'hFF12;
        @(negedge clk);
        chk_all("R10", 3, 5, 1, 2, 3, 0, 0, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_three();
                t_wide();
                t_two();
                t_one();
                t_zero();
                t_illegal();
                t_mode_ignored();
                t_timing();
                t_hold();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule